// File: doc/BRIEF.md
# Byte-Wide SPI Master with Armed Transmit Writes

This peripheral sits on a simple synchronous register bus and drives a four-wire SPI link as master. Software sets the enable and master bits, chooses clock polarity and phase, and programs a two-field baud register. Each byte goes through a one-byte transmit holding register into an 8-bit shift register. Bytes are sent MSB first, and the byte clocked in from MISO is kept for software to read.

Writes to the data register are guarded. A data write is taken only if the last status read returned the transmit-empty flag as 1. Any other data write is dropped with no trace. Right after initialisation the empty flag already reads 1, but a data write made without a status read first still does nothing. The receive-full flag clears only when a status read that saw it set is followed by a data read. A byte written while a transfer is running waits in the holding register and starts as soon as the current byte ends.

Top module: `spi_arm_master`

## Requirements
- R1: After reset, the status register (address 2) reads 0x80, with transmit-empty at bit 7 and receive-full at bit 6. The control register (address 0) reads 0, and SCK is low. A read returns its data on the clock edge after the read strobe.
- R2: A write to the data register (address 3) with no arming status read before it is ignored. No SCK edges follow, receive-full stays 0 and transmit-empty stays 1.
- R3: A status read that returns transmit-empty = 1 while the block is active arms exactly one data write. Any data write uses up the arming, so a second write without a new status read is dropped.
- R4: A held byte moves into the idle shifter on the next clock, and transmit-empty reads 1 again. The byte goes out in 16 SCK edges (8 bits, MSB first), and the received byte equals the 8 bits sampled from MISO.
- R5: A byte written while a transfer is in progress waits in the holding register and is sent right after the current byte. Both received bytes can be read in order.
- R6: Receive-full is set when a byte completes. A data read alone leaves it set. A status read that sees it set, followed by a data read, clears it.
- R7: Transfers need both the enable bit (control bit 0) and the master bit (control bit 1). With either bit clear, writes are dropped, and clearing them removes any pending arming.
- R8: Each SCK half period lasts (P+1)·2^R bus clocks. R is baud register bits [2:0] and P is bits [6:4].
- R9: SCK idles at the polarity bit (control bit 2). With the phase bit (control bit 3) at 0, MISO is sampled on the leading SCK edge; with it at 1, on the trailing edge.
- R10: A byte that completes while receive-full is still set replaces the held byte, so the data register returns the newest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 baud, 2 status, 3 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Say the accepted data write is sampled on clock edge W and h is the half period in bus clocks. The byte loads into the shifter at W+1, the SCK edges fall at W+1+k·h for k from 1 to 16, and receive-full is set at W+1+16h. The bench therefore waits 16h+6 cycles after a write before it reads status. It reads bus_rdata on the falling edge that follows each read strobe, when the registered value has settled. SCK half periods are measured from recorded toggle cycles, and the "nothing happened" cases are judged by toggle counts and status reads taken after a window longer than one full transfer.

// File: rtl/spi_arm_pkg.sv
package spi_arm_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_BAUD = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd3;

  // control register, LSB first: enable, master, polarity, phase
  typedef struct packed {
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_arm_baud.sv
module spi_arm_baud #(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = PRE_W + (1 << RATE_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    half    = (CNT_W'(pre) + CNT_W'(1)) << rate;
    half_m1 = half - CNT_W'(1);
  end

  assign tick = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_arm_shifter.sv
module spi_arm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              start,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [EDGE_W-1:0] edge_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              sck_q;
  logic              sample_now;
  logic              shift_now;
  logic              last_edge;

  // phase 0 samples on even (leading) edges, phase 1 on odd (trailing) edges
  assign sample_now = (edge_cnt[0] == cpha);
  assign shift_now  = !sample_now && !(cpha && edge_cnt == '0);
  assign last_edge  = (edge_cnt == EDGE_W'(EDGES - 1));

  assign done    = busy && tick && last_edge;
  assign rx_byte = sample_now ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
  assign sck     = sck_q;
  assign mosi    = tx_sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sck_q    <= 1'b0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (!active || !busy) begin
      busy     <= active && start;
      sck_q    <= cpol;
      edge_cnt <= '0;
      if (active && start) tx_sh <= load_byte;
    end else if (tick) begin
      sck_q    <= ~sck_q;
      edge_cnt <= edge_cnt + EDGE_W'(1);
      if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], miso};
      if (shift_now)  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (last_edge)  busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_arm_regs.sv
module spi_arm_regs
  import spi_arm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              shift_busy,
  input  logic              shift_done,
  input  logic [DATA_W-1:0] shift_rx,
  output ctrl_t             ctrl,
  output logic              active,
  output logic [PRE_W-1:0]  pre,
  output logic [RATE_W-1:0] rate,
  output logic              start,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_arm,
  output logic              buf_full,
  output logic              rx_full
);
  localparam int STAT_TXE = DATA_W - 1;
  localparam int STAT_RXF = DATA_W - 2;
  localparam int PRE_LSB  = DATA_W / 2;

  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] rd_mux;
  logic              rx_arm;

  assign active = ctrl.enable && ctrl.master;
  assign start  = active && buf_full && !shift_busy;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: rd_mux[CTRL_W-1:0] = ctrl;
      A_BAUD: begin
        rd_mux[PRE_LSB +: PRE_W] = pre;
        rd_mux[RATE_W-1:0]       = rate;
      end
      A_STAT: begin
        rd_mux[STAT_TXE] = !buf_full;
        rd_mux[STAT_RXF] = rx_full;
      end
      default: rd_mux = rx_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      pre       <= '0;
      rate      <= '0;
      tx_byte   <= '0;
      buf_full  <= 1'b0;
      tx_arm    <= 1'b0;
      rx_arm    <= 1'b0;
      rx_full   <= 1'b0;
      rx_data   <= '0;
      bus_rdata <= '0;
    end else begin
      if (start) buf_full <= 1'b0;

      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
          A_BAUD: begin
            pre  <= bus_wdata[PRE_LSB +: PRE_W];
            rate <= bus_wdata[RATE_W-1:0];
          end
          A_DATA: begin
            tx_arm <= 1'b0;
            if (tx_arm && active && !buf_full) begin
              tx_byte  <= bus_wdata;
              buf_full <= 1'b1;
            end
          end
          default: ;
        endcase
      end

      if (bus_rd) begin
        bus_rdata <= rd_mux;
        if (bus_addr == A_STAT) begin
          tx_arm <= active && !buf_full;
          rx_arm <= rx_full;
        end
        if (bus_addr == A_DATA) begin
          rx_arm <= 1'b0;
          if (rx_arm) rx_full <= 1'b0;
        end
      end

      if (shift_done) begin
        rx_data <= shift_rx;
        rx_full <= 1'b1;
      end

      if (!active) begin
        tx_arm   <= 1'b0;
        buf_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_arm_master.sv
module spi_arm_master
  import spi_arm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  ctrl_t             ctrl;
  logic              active;
  logic [PRE_W-1:0]  pre;
  logic [RATE_W-1:0] rate;
  logic              start;
  logic [DATA_W-1:0] tx_byte;
  logic              tx_arm;
  logic              buf_full;
  logic              rx_full;
  logic              shift_busy;
  logic              shift_done;
  logic [DATA_W-1:0] shift_rx;
  logic              tick;
  logic              cfg_cpol;

  assign cfg_cpol = ctrl.cpol;

  spi_arm_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shift_busy(shift_busy), .shift_done(shift_done), .shift_rx(shift_rx),
    .ctrl(ctrl), .active(active), .pre(pre), .rate(rate),
    .start(start), .tx_byte(tx_byte),
    .tx_arm(tx_arm), .buf_full(buf_full), .rx_full(rx_full)
  );

  spi_arm_baud #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_baud (
    .clk(clk), .rst(rst), .run(shift_busy && active),
    .pre(pre), .rate(rate), .tick(tick)
  );

  spi_arm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(active),
    .cpol(ctrl.cpol), .cpha(ctrl.cpha),
    .start(start), .load_byte(tx_byte), .tick(tick), .miso(spi_miso),
    .busy(shift_busy), .sck(spi_sck), .mosi(spi_mosi),
    .done(shift_done), .rx_byte(shift_rx)
  );
endmodule

// File: rtl/spi_arm_checker.sv
module spi_arm_checker
  import spi_arm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              tx_arm,
  input logic              buf_full,
  input logic              rx_full,
  input logic              active,
  input logic              busy,
  input logic              done,
  input logic              sck,
  input logic              cpol
);
  localparam int EDGES = 2 * DATA_W;
  localparam int TW    = $clog2(EDGES) + 2;

  logic          prev_sck;
  logic          prev_busy;
  logic [TW-1:0] tog_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sck  <= 1'b0;
      prev_busy <= 1'b0;
      tog_cnt   <= '0;
    end else begin
      prev_sck  <= sck;
      prev_busy <= busy;
      if (busy && !prev_busy) tog_cnt <= '0;
      else if (sck != prev_sck) tog_cnt <= tog_cnt + TW'(1);
    end
  end

  assert_unarmed_write_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA && !tx_arm && !buf_full) |=> !buf_full);

  assert_arm_consumed_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == A_DATA) |=> !tx_arm);

  assert_sixteen_edges_R4: assert property (@(posedge clk) disable iff (rst)
    (prev_busy && !busy && active) |-> ((tog_cnt + TW'(sck != prev_sck)) == TW'(EDGES)));

  assert_done_sets_rxf_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_full);

  assert_disable_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    !active |=> !tx_arm);

  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !prev_busy && $stable(cpol)) |-> (sck == cpol));
endmodule

bind spi_arm_master spi_arm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .tx_arm(tx_arm), .buf_full(buf_full), .rx_full(rx_full), .active(active),
  .busy(shift_busy), .done(shift_done), .sck(spi_sck), .cpol(cfg_cpol)
);

// File: tb/tb_spi_arm_master.sv
module tb_spi_arm_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sck;
  logic       spi_mosi;
  logic       spi_miso;
  logic       inv = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tog_cnt = 0;
  int tog_time [64];
  logic sck_prev = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // slave model: loopback, optionally inverted
  assign spi_miso = spi_mosi ^ inv;

  spi_arm_master dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    sck_prev <= spi_sck;
    if (spi_sck !== sck_prev) begin
      tog_time[tog_cnt % 64] <= cyc;
      tog_cnt <= tog_cnt + 1;
    end
  end

  // {cpol, cpha, pre[2:0], rate[2:0], tx[7:0], inv}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd0, 3'd0, 8'hA5, 1'b0},
    {1'b1, 1'b0, 3'd1, 3'd0, 8'h3C, 1'b1},
    {1'b0, 1'b1, 3'd0, 3'd2, 8'h81, 1'b0},
    {1'b1, 1'b1, 3'd2, 3'd1, 8'h5E, 1'b1},
    {1'b0, 1'b1, 3'd4, 3'd0, 8'h01, 1'b1},
    {1'b1, 1'b0, 3'd0, 3'd3, 8'hF0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state R1
    rd(2'd2, d); chk("R1 status after reset", d, 8'h80);
    rd(2'd0, d); chk("R1 ctrl after reset", d, 8'h00);
    chk("R1 sck idle low", spi_sck, 0);

    // vector table R4 R8 R9
    foreach (VEC[i]) begin
      logic [16:0] v;
      int h;
      v = VEC[i];
      h = (v[14:12] + 1) << v[11:9];
      inv = v[0];
      wr(2'd0, {4'b0, v[15], v[16], 2'b11});
      wr(2'd1, {1'b0, v[14:12], 1'b0, v[11:9]});
      idle(2);
      rd(2'd2, d);
      base = tog_cnt;
      wr(2'd3, v[8:1]);
      idle(16 * h + 6);
      chk("R4 sixteen sck edges", tog_cnt - base, 16);
      chk("R8 half period", tog_time[(base + 1) % 64] - tog_time[base % 64], h);
      chk("R9 sck idles at polarity", spi_sck, v[16]);
      rd(2'd2, d); chk("R6 rxf set after transfer", d, 8'hC0);
      rd(2'd3, d); chk("R4 R9 received byte", d, v[8:1] ^ {8{v[0]}});
      rd(2'd2, d); chk("R6 rxf cleared", d, 8'h80);
    end
    inv = 1'b0;

    // R2 unarmed first write, then R3 arming and consumption
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03);
    base = tog_cnt;
    wr(2'd3, 8'hA5);
    idle(40);
    chk("R2 no sck after unarmed write", tog_cnt - base, 0);
    rd(2'd2, d); chk("R2 status after unarmed write", d, 8'h80);
    base = tog_cnt;
    wr(2'd3, 8'h3C);
    wr(2'd3, 8'h77);
    idle(60);
    rd(2'd2, d); chk("R3 armed write completed", d, 8'hC0);
    rd(2'd3, d); chk("R3 armed byte received", d, 8'h3C);
    chk("R3 second write dropped", tog_cnt - base, 16);

    // R5 queued back-to-back, h = 4
    wr(2'd1, 8'h11);
    rd(2'd2, d);
    base = tog_cnt;
    wr(2'd3, 8'h11);
    rd(2'd2, d); chk("R4 txe back after load", d, 8'h80);
    wr(2'd3, 8'h22);
    idle(64);
    rd(2'd2, d); chk("R5 first byte done", d, 8'hC0);
    rd(2'd3, d); chk("R5 first byte", d, 8'h11);
    idle(70);
    rd(2'd2, d); chk("R5 second byte done", d, 8'hC0);
    rd(2'd3, d); chk("R5 second byte", d, 8'h22);
    chk("R5 edges for two bytes", tog_cnt - base, 32);

    // R6 data read alone keeps rxf
    rd(2'd2, d);
    wr(2'd3, 8'h5A);
    idle(72);
    rd(2'd3, d); chk("R6 data value", d, 8'h5A);
    rd(2'd2, d); chk("R6 data read alone keeps rxf", d, 8'hC0);
    rd(2'd3, d);
    rd(2'd2, d); chk("R6 status then data clears", d, 8'h80);

    // R10 overwrite
    wr(2'd3, 8'h96);
    idle(72);
    rd(2'd2, d);
    wr(2'd3, 8'hC3);
    idle(72);
    rd(2'd3, d); chk("R10 newest byte held", d, 8'hC3);

    // R7 enable and master both needed; disabling disarms
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd2, d);
    base = tog_cnt;
    wr(2'd3, 8'h44);
    idle(40);
    chk("R7 no transfer without master", tog_cnt - base, 0);
    wr(2'd0, 8'h03);
    rd(2'd2, d);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h03);
    base = tog_cnt;
    wr(2'd3, 8'h55);
    idle(40);
    chk("R7 disable removes arming", tog_cnt - base, 0);
    rd(2'd2, d); chk("R7 status after dropped write", d & 8'h80, 8'h80);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule